// File: doc/BRIEF.md
# I2C Target Engine with Qualified Address Slots

This block is the target side of an I2C bus interface, run by software that polls it. It watches the bus for START and STOP conditions and shifts in the first byte of each transfer. It then compares the seven address bits against four programmable slots. Each slot can be switched off through its bit 0. Slot 0 also has a qualifier mask, and any mask bit set to 1 makes that address bit a match whatever the bus carries.

When an event needs software, the engine raises a pending flag and reports a 2-bit event code. It then holds SCL low until software answers through one of two control strobes:
- **Continue**: acknowledges the byte, or sends the loaded byte.
- **Refuse**: sends NACK.

The events are an address match, a received data byte, and a transmit slot to fill. The captured address byte and the received data bytes are read from a data output. Transmit bytes are loaded through a data write strobe.

A NACK from the bus controller ends a read. A repeated START returns the engine to address matching. A STOP returns it to idle.

Top module: `i2c_tgt`

## Requirements
- R1: After reset, pend is 0 and the engine drives neither SCL (scl_oe=0) nor SDA (sda_oe=0).
- R2: Address bits 7:1 of the first byte after START are compared with bits 7:1 of each slot. A slot whose bit 0 is 1 never matches. With no match there is no pending event and SDA is not driven in the ninth clock.
- R3: For slot 0 only, an address bit whose qual_mask bit is 1 always matches. Unmasked bits must be equal.
- R4: match_idx gives the lowest-numbered matching slot. A slot holding 0x00 matches the general call address 0.
- R5: After a matching address byte: pend=1, slv_state=0, dat_rdata holds the whole byte including R/W in bit 0, and SCL is held low (scl_oe=1) for as long as pend is 1.
- R6: A ctl_cont pulse during state 0 or state 1 clears pend, releases SCL and drives ACK (SDA low) in the ninth clock. A ctl_nack pulse clears pend and leaves SDA released. After a NACK, no event is raised until the next START.
- R7: In a write transfer, each data byte (MSB first) raises pend with slv_state=1 and that byte on dat_rdata.
- R8: After the address ACK of a read transfer (R/W=1), pend rises with slv_state=2. A byte loaded with dat_wr followed by ctl_cont is driven onto SDA MSB first.
- R9: If the bus controller ACKs a transmitted byte, a new slv_state=2 event follows. If it NACKs, no event is raised and both lines stay released.
- R10: A repeated START in the middle of a byte discards that byte and restarts address matching. A STOP returns the engine to idle with pend=0.
- R11: Control strobes while pend=0 have no effect on the bus lines or on pend. dat_wr outside a state 2 event leaves dat_rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| slot_addr | input | 32 | Four slot bytes, slot i in bits 8i+7:8i; bits 7:1 address, bit 0 disable |
| qual_mask | input | 8 | Slot 0 qualifier mask, bits 7:1 used |
| ctl_cont | input | 1 | Strobe: acknowledge or send, and continue |
| ctl_nack | input | 1 | Strobe: refuse the byte (wins over ctl_cont) |
| dat_wr | input | 1 | Strobe: load dat_wdata as the transmit byte |
| dat_wdata | input | 8 | Transmit byte |
| pend | output | 1 | Event waiting for software |
| slv_state | output | 2 | 0 address, 1 received data, 2 transmit ready |
| match_idx | output | 2 | Index of the matched slot |
| dat_rdata | output | 8 | Captured address or received byte |

## Verification
The hardest cases to reach are those where the bus controller and the engine act on the clock line at the same time. One is a repeated START arriving partway through a data byte. Another is a NACK from the controller straight after a transmitted byte, which must leave both lines free with no event raised. The bench's open-drain controller model waits for SCL to actually go high before each bit, so every stretch is honoured. Directed sequences cut a byte after four bits to force the repeated START, and end a read with a NACK. Random address and payload traffic then covers masked, disabled and general call slots against a bench-side slot match function.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    EV_ADDR = 2'd0,
    EV_RX   = 2'd1,
    EV_TX   = 2'd2
  } ev_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_HOLD, PH_ACK, PH_RX, PH_TX, PH_TXACK, PH_SKIP
  } phase_t;

  // A slot hits when enabled and every unmasked address bit agrees.
  function automatic logic slot_hit(input logic [BYTE_W-1:0] cfg,
                                    input logic [BYTE_W-1:0] mask,
                                    input logic [BYTE_W-1:0] rx);
    logic [BYTE_W-1:0] diff;
    diff = (rx ^ cfg) & ~mask & {{(BYTE_W-1){1'b1}}, 1'b0};
    return (cfg[0] == 1'b0) && (diff == '0);
  endfunction
endpackage

// File: rtl/i2c_tgt_edge.sv
module i2c_tgt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_q, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; scl_p <= 1'b1;
      sda_q <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i; scl_p <= scl_q;
      sda_q <= sda_i; sda_p <= sda_q;
    end
  end

  assign ev_rise  = scl_q & ~scl_p;
  assign ev_fall  = ~scl_q & scl_p;
  assign ev_start = scl_q & scl_p & sda_p & ~sda_q;
  assign ev_stop  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match #(
  parameter int NUM_SLOTS = 4,
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS*8-1:0] slot_addr,
  input  logic [7:0]             qual_mask,
  input  logic [7:0]             rx_byte,
  output logic                   hit,
  output logic [IW-1:0]          hit_idx
);
  import i2c_tgt_pkg::*;
  logic [NUM_SLOTS-1:0] hits;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s == 0) begin : g_masked
      assign hits[s] = slot_hit(slot_addr[8*s +: 8], qual_mask, rx_byte);
    end else begin : g_plain
      assign hits[s] = slot_hit(slot_addr[8*s +: 8], 8'h00, rx_byte);
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (hits[s]) hit_idx = IW'(s);
  end
  assign hit = |hits;
endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core #(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_q,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          hit,
  input  logic [IW-1:0] hit_idx,
  input  logic          ctl_cont,
  input  logic          ctl_nack,
  input  logic          dat_wr,
  input  logic [7:0]    dat_wdata,
  output logic [7:0]    rx_byte,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          pend,
  output logic [1:0]    slv_state,
  output logic [IW-1:0] match_idx,
  output logic [7:0]    dat_rdata
);
  import i2c_tgt_pkg::*;
  phase_t     ph;
  logic [3:0] cnt;
  logic [7:0] tx_sh;
  logic       rw, go_tx, mack;
  logic       ctl_any;

  assign ctl_any = ctl_cont | ctl_nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; rx_byte <= '0; tx_sh <= '0;
      rw <= 1'b0; go_tx <= 1'b0; mack <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; pend <= 1'b0;
      slv_state <= EV_ADDR; match_idx <= '0; dat_rdata <= '0;
    end else if (ev_start) begin
      ph <= PH_ADDR; cnt <= '0; pend <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else if (ev_stop) begin
      ph <= PH_IDLE; pend <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      unique case (ph)
        PH_ADDR, PH_RX: begin
          if (ev_rise) begin
            rx_byte <= {rx_byte[6:0], sda_q};
            cnt     <= cnt + 4'd1;
          end else if (ev_fall && cnt == 4'd8) begin
            if (ph == PH_RX || hit) begin
              dat_rdata <= rx_byte;
              pend      <= 1'b1;
              scl_oe    <= 1'b1;
              ph        <= PH_HOLD;
              if (ph == PH_ADDR) begin
                slv_state <= EV_ADDR;
                match_idx <= hit_idx;
                rw        <= rx_byte[0];
              end else begin
                slv_state <= EV_RX;
              end
            end else begin
              ph <= PH_SKIP;
            end
          end
        end
        PH_HOLD: begin
          if (dat_wr && slv_state == EV_TX) dat_rdata <= dat_wdata;
          if (ctl_any) begin
            pend   <= 1'b0;
            scl_oe <= 1'b0;
            if (ctl_nack) begin
              ph <= PH_SKIP;
            end else if (slv_state == EV_TX) begin
              tx_sh  <= dat_rdata;
              sda_oe <= ~dat_rdata[7];
              cnt    <= '0;
              ph     <= PH_TX;
            end else begin
              sda_oe <= 1'b1;
              go_tx  <= (slv_state == EV_ADDR) && rw;
              ph     <= PH_ACK;
            end
          end
        end
        PH_ACK: begin
          if (ev_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (go_tx) begin
              pend <= 1'b1; slv_state <= EV_TX; scl_oe <= 1'b1; ph <= PH_HOLD;
            end else begin
              ph <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (ev_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;
              ph     <= PH_TXACK;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
              cnt    <= cnt + 4'd1;
            end
          end
        end
        PH_TXACK: begin
          if (ev_rise) mack <= ~sda_q;
          else if (ev_fall) begin
            if (mack) begin
              pend <= 1'b1; slv_state <= EV_TX; scl_oe <= 1'b1; ph <= PH_HOLD;
            end else begin
              ph <= PH_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt #(
  parameter int NUM_SLOTS = 4,
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   scl_oe,
  output logic                   sda_oe,
  input  logic [NUM_SLOTS*8-1:0] slot_addr,
  input  logic [7:0]             qual_mask,
  input  logic                   ctl_cont,
  input  logic                   ctl_nack,
  input  logic                   dat_wr,
  input  logic [7:0]             dat_wdata,
  output logic                   pend,
  output logic [1:0]             slv_state,
  output logic [IW-1:0]          match_idx,
  output logic [7:0]             dat_rdata
);
  logic          sda_q, ev_rise, ev_fall, ev_start, ev_stop;
  logic          hit;
  logic [IW-1:0] hit_idx;
  logic [7:0]    rx_byte;

  i2c_tgt_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_q(sda_q),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop)
  );

  i2c_tgt_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .slot_addr(slot_addr), .qual_mask(qual_mask), .rx_byte(rx_byte),
    .hit(hit), .hit_idx(hit_idx)
  );

  i2c_tgt_core #(.IW(IW)) u_core (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop), .hit(hit), .hit_idx(hit_idx),
    .ctl_cont(ctl_cont), .ctl_nack(ctl_nack), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .rx_byte(rx_byte), .scl_oe(scl_oe), .sda_oe(sda_oe), .pend(pend),
    .slv_state(slv_state), .match_idx(match_idx), .dat_rdata(dat_rdata)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       pend,
  input logic [1:0] slv_state,
  input logic       ctl_cont,
  input logic       ctl_nack,
  input logic       ev_stop
);
  AST_PEND_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> scl_oe); // R5

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (slv_state != 2'd3)); // R5

  AST_CTL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && (ctl_cont || ctl_nack)) |=> (!pend && !scl_oe)); // R6

  AST_NACK_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && slv_state == 2'd1 && ctl_nack) |=> !sda_oe); // R6

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!pend && !scl_oe && !sda_oe)); // R10

  AST_IDLE_CTL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && (ctl_cont || ctl_nack) && !scl_oe) |=> !pend); // R11

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!scl_i || $past(scl_oe))); // R8
endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .pend(pend), .slv_state(slv_state), .ctl_cont(ctl_cont), .ctl_nack(ctl_nack),
  .ev_stop(ev_stop)
);

// File: tb/i2c_tgt_test.sv
module i2c_tgt_test;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, pend;
  logic [1:0] slv_state, match_idx;
  logic [7:0] dat_rdata;
  logic [31:0] slot_addr;
  logic [7:0] qual_mask = 8'h06;
  logic ctl_cont = 1'b0, ctl_nack = 1'b0, dat_wr = 1'b0;
  logic [7:0] dat_wdata = 8'h00;
  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;
  int total = 0, bad = 0;
  logic done = 1'b0;

  // slot0 0x50 masked, slot1 general call, slot2 0x3C disabled, slot3 0x12
  assign slot_addr = {8'h24, 8'h79, 8'h00, 8'hA0};

  always #4 clk = ~clk;

  i2c_tgt uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .slot_addr(slot_addr), .qual_mask(qual_mask),
    .ctl_cont(ctl_cont), .ctl_nack(ctl_nack), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .pend(pend), .slv_state(slv_state), .match_idx(match_idx), .dat_rdata(dat_rdata)
  );

  function automatic int exp_slot(input logic [6:0] a);
    for (int s = 0; s < 4; s++) begin
      logic [7:0] c;
      logic [6:0] m;
      c = slot_addr[8*s +: 8];
      m = (s == 0) ? qual_mask[7:1] : 7'h00;
      if (!c[0] && ((a & ~m) == (c[7:1] & ~m))) return s;
    end
    return -1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_scl_high();
    while (scl_bus !== 1'b1) tick(1);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; tick(Q);
    m_scl = 1'b1; wait_scl_high(); tick(Q);
    r = sda_bus;
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; wait_scl_high(); tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; wait_scl_high(); tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) clk_bit(1'b1, b[i]);
  endtask

  task automatic pulse(input logic c, input logic n);
    ctl_cont = c; ctl_nack = n; tick(1);
    ctl_cont = 1'b0; ctl_nack = 1'b0; tick(1);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic r;
    logic [7:0] rb;
    void'($urandom(32'd17));
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 pend", pend, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);

    // R11: strobes while idle
    pulse(1, 0); pulse(0, 1);
    dat_wr = 1'b1; dat_wdata = 8'hEE; tick(1); dat_wr = 1'b0; tick(2);
    chk("R11 idle pend", pend, 0);
    chk("R11 idle lines", {scl_oe, sda_oe}, 0);
    chk("R11 idle rdata", dat_rdata, 0);

    // Write to slot 3
    bus_start(); send_byte(8'h24);
    chk("R5 pend", pend, 1);
    chk("R5 state", slv_state, 0);
    chk("R5 rdata", dat_rdata, 8'h24);
    chk("R5 stretch", scl_oe, 1);
    chk("R4 idx3", match_idx, 3);
    pulse(1, 0); clk_bit(1'b1, r);
    chk("R6 ack", r, 0);
    send_byte(8'hA5);
    chk("R7 pend", pend, 1);
    chk("R7 state", slv_state, 1);
    chk("R7 data", dat_rdata, 8'hA5);
    dat_wr = 1'b1; dat_wdata = 8'h11; tick(1); dat_wr = 1'b0; tick(1);
    chk("R11 dat_wr in rx", dat_rdata, 8'hA5);
    pulse(1, 0); clk_bit(1'b1, r);
    chk("R6 data ack", r, 0);
    send_byte(8'h3C);
    chk("R7 data2", dat_rdata, 8'h3C);
    pulse(0, 1); clk_bit(1'b1, r);
    chk("R6 nack", r, 1);
    send_byte(8'h77); clk_bit(1'b1, r);
    chk("R6 ignored after nack", {pend, r}, 2'b01);
    bus_stop();
    chk("R10 stop idle", pend, 0);

    // Disabled slot 2
    bus_start(); send_byte(8'h78);
    chk("R2 disabled no pend", pend, 0);
    clk_bit(1'b1, r);
    chk("R2 disabled no ack", r, 1);
    bus_stop();

    // Masked slot 0
    bus_start(); send_byte(8'hA6);
    chk("R3 masked match", {pend, match_idx}, {1'b1, 2'd0});
    pulse(1, 0); clk_bit(1'b1, r); bus_stop();
    bus_start(); send_byte(8'hA8);
    chk("R3 unmasked bit mismatch", pend, 0);
    clk_bit(1'b1, r); bus_stop();

    // General call
    bus_start(); send_byte(8'h00);
    chk("R4 general call", {pend, match_idx}, {1'b1, 2'd1});
    pulse(1, 0); clk_bit(1'b1, r); bus_stop();

    // Read from slot 3
    bus_start(); send_byte(8'h25);
    chk("R5 read addr rdata", dat_rdata, 8'h25);
    pulse(1, 0); clk_bit(1'b1, r);
    chk("R8 tx pend", {pend, slv_state}, {1'b1, 2'd2});
    dat_wr = 1'b1; dat_wdata = 8'hC3; tick(1); dat_wr = 1'b0; tick(1);
    pulse(1, 0); recv_byte(rb);
    chk("R8 tx byte", rb, 8'hC3);
    clk_bit(1'b0, r);
    chk("R9 master ack next", {pend, slv_state}, {1'b1, 2'd2});
    dat_wr = 1'b1; dat_wdata = 8'h5A; tick(1); dat_wr = 1'b0; tick(1);
    pulse(1, 0); recv_byte(rb);
    chk("R8 tx byte2", rb, 8'h5A);
    clk_bit(1'b1, r);
    chk("R9 master nak", {pend, scl_oe, sda_oe}, 0);
    bus_stop();

    // Repeated start mid byte
    bus_start(); send_byte(8'h24); pulse(1, 0); clk_bit(1'b1, r);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, r);
    bus_start(); send_byte(8'hA1);
    chk("R10 rstart readdress", {pend, slv_state, match_idx, dat_rdata}, {1'b1, 2'd0, 2'd0, 8'hA1});
    pulse(0, 1); clk_bit(1'b1, r);
    bus_stop();
    chk("R10 stop after rstart", {pend, scl_oe, sda_oe}, 0);

    // Random write traffic
    for (int k = 0; k < 24; k++) begin
      logic [6:0] a;
      int e;
      int nb;
      case ($urandom % 4)
        0: a = 7'h12;
        1: a = 7'h50 | 7'($urandom % 8);
        2: a = 7'($urandom);
        default: a = 7'h3C;
      endcase
      e = exp_slot(a);
      bus_start(); send_byte({a, 1'b0});
      if (e >= 0) begin
        chk("R2 rnd match", {pend, match_idx, dat_rdata}, {1'b1, 2'(e), a, 1'b0});
        pulse(1, 0); clk_bit(1'b1, r);
        nb = 1 + int'($urandom % 3);
        for (int j = 0; j < nb; j++) begin
          logic [7:0] d;
          d = 8'($urandom);
          send_byte(d);
          chk("R7 rnd data", {pend, slv_state, dat_rdata}, {1'b1, 2'd1, d});
          pulse(1, 0); clk_bit(1'b1, r);
          chk("R6 rnd ack", r, 0);
        end
      end else begin
        chk("R2 rnd miss", pend, 0);
        clk_bit(1'b1, r);
        chk("R2 rnd no ack", r, 1);
      end
      bus_stop();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule